// File: doc/BRIEF.md
# Segment Sync Polarity Decision

This block works out whether a received baseband symbol stream arrives with normal or inverted polarity. A separate timing circuit marks the four sync positions at the start of every segment. At each of these positions the block takes the sign bit of the symbol. After the fourth position it compares the captured four-bit word with the expected sync form and with the bit-inverted form of it. Two consecutive segments must agree before the decision moves to a new polarity. A single damaged sync therefore cannot flip the result.

The block drives a complementary pair of polarity flags to the correction datapath, plus a status copy of the negative flag for the register interface. Until segment sync lock is present, both flags stay low. A control-register override can force either polarity whatever is detected.

Top module: `polarity_decider`

## Requirements
- R1: After synchronous active-high reset, pol_pos_o, pol_neg_o and pol_neg_status_o are all 0.
- R2: While seg_lock_i is 0, pol_pos_o and pol_neg_o are both 0 on the next clock edge, whatever the symbol and override inputs are.
- R3: The sign bits of the four sync positions, first received first, form the pattern 1,0,0,1. When two consecutive segments carry this pattern with lock present and force_en_i at 0, the outputs become pol_pos_o=1 and pol_neg_o=0 on the edge that samples the fourth sync symbol of the second segment.
- R4: Under the same conditions, two consecutive segments carrying 0,1,1,0 give pol_pos_o=0 and pol_neg_o=1.
- R5: A single segment whose pattern differs from the current decision does not change the outputs. Straight after lock is gained, one segment alone leaves both outputs at 0.
- R6: A captured pattern that matches neither 1,0,0,1 nor 0,1,1,0 keeps the current decision and breaks any run of agreeing segments.
- R7: With lock present and force_en_i at 1, force_neg_i=0 gives pol_pos_o=1, pol_neg_o=0 and force_neg_i=1 gives pol_pos_o=0, pol_neg_o=1 on the next edge. The detected pattern has no effect on the outputs.
- R8: pol_neg_status_o always equals pol_neg_o.
- R9: pol_pos_o and pol_neg_o are never 1 together.
- R10: Dropping lock clears the stored decision and the agreement run. After lock returns, two agreeing segments are needed again before any output goes high.
- R11: A sign bit is captured only when sym_valid_i and sync_pos_i are both 1. Symbols that have only one of the two strobes do not affect the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_sign_i | input | 1 | Sign bit of the current symbol (1 = positive) |
| sync_pos_i | input | 1 | Marks a symbol in one of the sync positions |
| seg_lock_i | input | 1 | Segment sync lock indicator |
| force_en_i | input | 1 | Override enable control bit |
| force_neg_i | input | 1 | Forced polarity when override is on (1 = negative) |
| pol_pos_o | output | 1 | Positive polarity flag |
| pol_neg_o | output | 1 | Negative polarity flag |
| pol_neg_status_o | output | 1 | Read-back copy of the negative flag |

## Verification
The bench builds the block with its defaults: a four-symbol sync of 1,0,0,1 and an agreement count of two. With these values a lone segment, a lone contrary segment and a run broken by an unmatched pattern all differ visibly from an accepted change. The bench interleaves symbols that carry only one of the two strobes between the sync symbols. A wrong capture qualifier then corrupts the word. Lock drop and relock, and the override applied over contrary detection, complete the scenarios.

// File: rtl/polarity_pkg.sv
package polarity_pkg;
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_POS  = 2'd1,
    DEC_NEG  = 2'd2
  } dec_t;
endpackage

// File: rtl/sync_capture.sv
module sync_capture #(
  parameter int SYNC_LEN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lock_i,
  input  logic                sym_valid_i,
  input  logic                sym_sign_i,
  input  logic                sync_pos_i,
  output logic                eval_o,
  output logic [SYNC_LEN-1:0] word_o
);
  localparam int CNT_W = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_LEN - 1);

  logic [SYNC_LEN-1:0] shreg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                take;

  assign take   = sym_valid_i && sync_pos_i;
  assign word_o = {shreg_q[SYNC_LEN-2:0], sym_sign_i};
  assign eval_o = take && lock_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !lock_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (take) begin
      shreg_q <= word_o;
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pattern_classify.sv
module pattern_classify #(
  parameter int                SYNC_LEN = 4,
  parameter logic [SYNC_LEN-1:0] PATTERN = 4'b1001
) (
  input  logic [SYNC_LEN-1:0] word_i,
  output logic                match_pos_o,
  output logic                match_neg_o
);
  logic [SYNC_LEN-1:0] same;

  for (genvar i = 0; i < SYNC_LEN; i++) begin : g_bit
    assign same[i] = (word_i[i] == PATTERN[i]);
  end

  assign match_pos_o = &same;
  assign match_neg_o = ~|same;
endmodule

// File: rtl/polarity_tracker.sv
module polarity_tracker
  import polarity_pkg::*;
#(
  parameter int AGREE_CNT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  input  logic eval_i,
  input  logic match_pos_i,
  input  logic match_neg_i,
  output dec_t dec_next_o
);
  localparam int CNT_W = $clog2(AGREE_CNT + 1);
  localparam logic [CNT_W-1:0] NEED = CNT_W'(AGREE_CNT);

  dec_t             dec_q, dec_d, cand_q, cand_d, hit;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    dec_d  = dec_q;
    cand_d = cand_q;
    cnt_d  = cnt_q;
    hit    = match_pos_i ? DEC_POS : DEC_NEG;
    if (!lock_i) begin
      dec_d  = DEC_NONE;
      cand_d = DEC_NONE;
      cnt_d  = '0;
    end else if (eval_i) begin
      if (!match_pos_i && !match_neg_i) begin
        cand_d = DEC_NONE;
        cnt_d  = '0;
      end else begin
        if (hit == dec_q) begin
          cand_d = DEC_NONE;
          cnt_d  = '0;
        end else if (hit == cand_q) begin
          cnt_d = cnt_q + 1'b1;
        end else begin
          cand_d = hit;
          cnt_d  = CNT_W'(1);
        end
        if (cnt_d >= NEED) begin
          dec_d  = hit;
          cand_d = DEC_NONE;
          cnt_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q  <= DEC_NONE;
      cand_q <= DEC_NONE;
      cnt_q  <= '0;
    end else begin
      dec_q  <= dec_d;
      cand_q <= cand_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dec_next_o = dec_d;
endmodule

// File: rtl/polarity_decider.sv
module polarity_decider
  import polarity_pkg::*;
#(
  parameter int                  SYNC_LEN  = 4,
  parameter logic [SYNC_LEN-1:0] PATTERN   = 4'b1001,
  parameter int                  AGREE_CNT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sym_valid_i,
  input  logic sym_sign_i,
  input  logic sync_pos_i,
  input  logic seg_lock_i,
  input  logic force_en_i,
  input  logic force_neg_i,
  output logic pol_pos_o,
  output logic pol_neg_o,
  output logic pol_neg_status_o
);
  logic                eval;
  logic [SYNC_LEN-1:0] word;
  logic                m_pos, m_neg;
  dec_t                dec_next;
  logic                pos_q, neg_q;

  sync_capture #(.SYNC_LEN(SYNC_LEN)) u_capture (
    .clk(clk), .rst(rst), .lock_i(seg_lock_i),
    .sym_valid_i(sym_valid_i), .sym_sign_i(sym_sign_i), .sync_pos_i(sync_pos_i),
    .eval_o(eval), .word_o(word)
  );

  pattern_classify #(.SYNC_LEN(SYNC_LEN), .PATTERN(PATTERN)) u_classify (
    .word_i(word), .match_pos_o(m_pos), .match_neg_o(m_neg)
  );

  polarity_tracker #(.AGREE_CNT(AGREE_CNT)) u_tracker (
    .clk(clk), .rst(rst), .lock_i(seg_lock_i), .eval_i(eval),
    .match_pos_i(m_pos), .match_neg_i(m_neg), .dec_next_o(dec_next)
  );

  always_ff @(posedge clk) begin
    if (rst || !seg_lock_i) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (force_en_i) begin
      pos_q <= !force_neg_i;
      neg_q <= force_neg_i;
    end else begin
      pos_q <= (dec_next == DEC_POS);
      neg_q <= (dec_next == DEC_NEG);
    end
  end

  assign pol_pos_o        = pos_q;
  assign pol_neg_o        = neg_q;
  assign pol_neg_status_o = neg_q;
endmodule

// File: rtl/polarity_decider_chk.sv
module polarity_decider_chk (
  input logic clk,
  input logic rst,
  input logic sym_valid_i,
  input logic sync_pos_i,
  input logic seg_lock_i,
  input logic force_en_i,
  input logic force_neg_i,
  input logic pol_pos_o,
  input logic pol_neg_o,
  input logic pol_neg_status_o
);
  p_unlocked_low_r2: assert property (@(posedge clk) disable iff (rst)
    !seg_lock_i |=> (!pol_pos_o && !pol_neg_o));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(pol_pos_o && pol_neg_o));

  p_status_copy_r8: assert property (@(posedge clk) disable iff (rst)
    pol_neg_status_o == pol_neg_o);

  p_forced_r7: assert property (@(posedge clk) disable iff (rst)
    (seg_lock_i && force_en_i) |=>
      (pol_neg_o == $past(force_neg_i)) && (pol_pos_o != $past(force_neg_i)));

  p_hold_between_syncs_r6: assert property (@(posedge clk) disable iff (rst)
    (seg_lock_i && !force_en_i && !(sym_valid_i && sync_pos_i) &&
     $past(seg_lock_i && !force_en_i)) |=> $stable({pol_pos_o, pol_neg_o}));
endmodule

bind polarity_decider polarity_decider_chk u_chk (
  .clk(clk), .rst(rst), .sym_valid_i(sym_valid_i), .sync_pos_i(sync_pos_i),
  .seg_lock_i(seg_lock_i), .force_en_i(force_en_i), .force_neg_i(force_neg_i),
  .pol_pos_o(pol_pos_o), .pol_neg_o(pol_neg_o), .pol_neg_status_o(pol_neg_status_o)
);

// File: tb/test_polarity_decider.sv
module test_polarity_decider;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0, sym_sign = 1'b0, sync_pos = 1'b0;
  logic seg_lock = 1'b0, force_en = 1'b0, force_neg = 1'b0;
  logic pol_pos, pol_neg, pol_stat;
  int   total = 0;
  int   bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  polarity_decider i_polarity_decider (
    .clk(clk), .rst(rst), .sym_valid_i(sym_valid), .sym_sign_i(sym_sign),
    .sync_pos_i(sync_pos), .seg_lock_i(seg_lock), .force_en_i(force_en),
    .force_neg_i(force_neg), .pol_pos_o(pol_pos), .pol_neg_o(pol_neg),
    .pol_neg_status_o(pol_stat)
  );

  task automatic check(input logic ep, input logic en, input string req);
    total++;
    if (pol_pos !== ep || pol_neg !== en || pol_stat !== en) begin
      bad++;
      $display("FAIL %s: pos/neg/stat=%b%b%b expected %b%b%b", req,
               pol_pos, pol_neg, pol_stat, ep, en, en);
    end
  endtask

  task automatic sym(input logic v, input logic s, input logic p);
    @(negedge clk);
    sym_valid = v; sym_sign = s; sync_pos = p;
  endtask

  // four sync symbols, first element first, then one data symbol
  task automatic segment(input logic [3:0] pat, input bit noisy = 0);
    for (int i = 3; i >= 0; i--) begin
      if (noisy) begin
        sym(1'b1, ~pat[i], 1'b0);  // valid only
        sym(1'b0, ~pat[i], 1'b1);  // strobe only
      end
      sym(1'b1, pat[i], 1'b1);
    end
    sym(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check(1'b0, 1'b0, "R1 reset");
  endtask

  task automatic t_unlocked();
    segment(4'b1001); segment(4'b1001);
    check(1'b0, 1'b0, "R2 no lock");
    force_en = 1'b1; sym(1'b0, 1'b0, 1'b0); sym(1'b0, 1'b0, 1'b0);
    check(1'b0, 1'b0, "R2 no lock with override");
    force_en = 1'b0;
  endtask

  task automatic t_detect();
    seg_lock = 1'b1;
    segment(4'b1001);
    check(1'b0, 1'b0, "R5 one segment after lock");
    segment(4'b1001);
    check(1'b1, 1'b0, "R3 positive");
    segment(4'b0110);
    check(1'b1, 1'b0, "R5 lone contrary segment");
    segment(4'b1001);
    segment(4'b0110);
    check(1'b1, 1'b0, "R5 run restarted");
    segment(4'b0110);
    check(1'b0, 1'b1, "R4 negative, R8 status");
  endtask

  task automatic t_unmatched();
    segment(4'b1001);
    segment(4'b1111);
    check(1'b0, 1'b1, "R6 unmatched keeps");
    segment(4'b1001);
    check(1'b0, 1'b1, "R6 run broken");
    segment(4'b1001);
    check(1'b1, 1'b0, "R6 new run accepted");
  endtask

  task automatic t_strobes();
    segment(4'b0110, 1);
    segment(4'b0110, 1);
    check(1'b0, 1'b1, "R11 single-strobe symbols ignored");
  endtask

  task automatic t_override();
    force_en = 1'b1; force_neg = 1'b0;
    sym(1'b0, 1'b0, 1'b0); sym(1'b0, 1'b0, 1'b0);
    check(1'b1, 1'b0, "R7 forced positive");
    force_neg = 1'b1;
    sym(1'b0, 1'b0, 1'b0); sym(1'b0, 1'b0, 1'b0);
    check(1'b0, 1'b1, "R7 forced negative");
    segment(4'b1001); segment(4'b1001);
    check(1'b0, 1'b1, "R7 detection ignored");
    force_en = 1'b0; force_neg = 1'b0;
  endtask

  task automatic t_relock();
    @(negedge clk); seg_lock = 1'b0;
    @(negedge clk);
    check(1'b0, 1'b0, "R2 lock dropped");
    seg_lock = 1'b1;
    segment(4'b1001);
    check(1'b0, 1'b0, "R10 decision cleared");
    segment(4'b1001);
    check(1'b1, 1'b0, "R10 reacquired");
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unlocked();
    t_detect();
    t_unmatched();
    t_strobes();
    t_override();
    t_relock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule